// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A lookup port takes the branch address and the sign of its displacement and returns a taken or not-taken guess, with no clock edge in between. A separate update port trains the block with the real outcome once the branch has resolved. A 2-bit mode input selects one of three strategies at run time: always fall through, backward-taken by displacement sign, or history-based.

The history store is a tagged, 2-way set-associative table. Each entry holds a 2-bit saturating counter. Each set keeps one least-recently-used bit that chooses the way a new branch replaces. A flush input empties the whole table in one cycle. The block computes no targets, keeps no return stack and does no pipeline recovery.

Top module: `bdir_predictor`

## Requirements
- R1: After reset every table entry is invalid, so `lk_hit_o` is 0 for every address.
- R2: With `mode_i` = 00, `lk_taken_o` is 0 whatever the table holds and whatever the displacement sign is.
- R3: With `mode_i` = 01, `lk_taken_o` equals `lk_disp_neg_i`, whether or not the table hits.
- R4: With `mode_i` = 10 or 11 and a table hit, `lk_taken_o` is bit 1 of the matching counter. On a miss it equals `lk_disp_neg_i`.
- R5: The set is chosen by PC bits [7:2] and the tag is PC bits [15:8]. PC bits [1:0] and [31:16] have no effect on hit or prediction.
- R6: Counters use 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. An update that hits moves the counter one step toward the outcome and saturates at 00 and 11.
- R7: An update that misses writes the set's least-recently-used way with the new tag. Its counter is set to 10 for a taken outcome or 01 for a not-taken outcome.
- R8: Each set has one recency bit naming the way to replace. A valid lookup that hits, or an allocation, marks the touched way as most recent. Update hits leave the bit alone.
- R9: The victim way is chosen from the recency state held before the current cycle. When a lookup hit and an allocation touch the same set in one cycle, the allocation's recency marking wins.
- R10: `flush_i` clears every valid bit and every recency bit in one cycle and overrides an update in the same cycle.
- R11: Lookups see the table state from before the current edge. An update becomes visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the history table |
| mode_i | input | 2 | Strategy: 00 never, 01 displacement, 10/11 history |
| lk_valid_i | input | 1 | Lookup is real (enables recency marking) |
| lk_pc_i | input | PC_W | Branch address being predicted |
| lk_disp_neg_i | input | 1 | Branch displacement is negative |
| lk_taken_o | output | 1 | Predicted direction |
| lk_hit_o | output | 1 | Lookup address matched a valid entry |
| up_valid_i | input | 1 | Resolved branch present on update port |
| up_pc_i | input | PC_W | Address of the resolved branch |
| up_taken_i | input | 1 | Actual outcome of the resolved branch |

## Verification
A directed pass walks a counter through a fixed outcome string that crosses both saturation points, so each step's guess can be worked out by arithmetic. Conflict patterns put three or four tags into one set, some with a lookup and an allocation in the same cycle. The line of hits and misses that follows shows whether replacement used the right recency bit and which marking won. Address aliases that differ only in ignored bits, next to addresses that differ by one index or tag bit, separate correct field slicing from off-by-one slicing. A long random stream over a few sets, all four mode codes and occasional flushes is then compared every cycle against a behavioural model built from the requirements.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    typedef enum logic [1:0] {
        MODE_NEVER = 2'b00,
        MODE_DISP  = 2'b01,
        MODE_HIST  = 2'b10,
        MODE_HIST2 = 2'b11
    } mode_e;

    // one saturating training step toward the resolved outcome
    function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
        ctr_t r;
        if (taken) r = (c == CTR_ST)  ? c : c + 2'd1;
        else       r = (c == CTR_SNT) ? c : c - 2'd1;
        return r;
    endfunction

    // starting value of a freshly allocated entry
    function automatic ctr_t ctr_seed(input logic taken);
        return taken ? CTR_WT : CTR_WNT;
    endfunction

endpackage

// File: rtl/bdp_way_match.sv
module bdp_way_match #(
    parameter int TAG_W = 8,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       valid_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      way_o
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
    end

    always_comb begin
        hit_o = |match;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/bdp_strategy.sv
module bdp_strategy
    import bdp_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       disp_neg_i,
    input  logic       hit_i,
    input  ctr_t       ctr_i,
    output logic       taken_o
);

    always_comb begin
        unique case (mode_e'(mode_i))
            MODE_NEVER: taken_o = 1'b0;
            MODE_DISP:  taken_o = disp_neg_i;
            default:    taken_o = hit_i ? ctr_i[1] : disp_neg_i;
        endcase
    end

endmodule

// File: rtl/bdp_table.sv
module bdp_table
    import bdp_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int TAG_W = 8,
    localparam int SETS = 1 << SET_W,
    localparam int WAYS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    // lookup side
    input  logic                  lk_valid_i,
    input  logic [SET_W-1:0]      lk_set_i,
    input  logic                  lk_hit_i,
    input  logic                  lk_way_i,
    output logic [WAYS-1:0]       lk_valid_o,
    output logic [WAYS*TAG_W-1:0] lk_tags_o,
    output logic [WAYS*2-1:0]     lk_ctrs_o,
    // update side
    input  logic                  up_valid_i,
    input  logic [SET_W-1:0]      up_set_i,
    input  logic [TAG_W-1:0]      up_tag_i,
    input  logic                  up_hit_i,
    input  logic                  up_way_i,
    input  logic                  up_taken_i,
    output logic [WAYS-1:0]       up_valid_o,
    output logic [WAYS*TAG_W-1:0] up_tags_o
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][1:0]       ctr;
        logic [SETS-1:0]                      lru;   // way to replace next
    } tbl_t;

    tbl_t s_d, s_q;
    logic victim;

    // read ports (state before the edge)
    always_comb begin
        lk_valid_o = s_q.valid[lk_set_i];
        lk_tags_o  = s_q.tag[lk_set_i];
        lk_ctrs_o  = s_q.ctr[lk_set_i];
        up_valid_o = s_q.valid[up_set_i];
        up_tags_o  = s_q.tag[up_set_i];
    end

    always_comb begin
        s_d    = s_q;
        victim = s_q.lru[up_set_i];

        if (lk_valid_i && lk_hit_i) begin
            s_d.lru[lk_set_i] = ~lk_way_i;
        end

        if (up_valid_i) begin
            if (up_hit_i) begin
                s_d.ctr[up_set_i][up_way_i] =
                    ctr_train(s_q.ctr[up_set_i][up_way_i], up_taken_i);
            end else begin
                s_d.valid[up_set_i][victim] = 1'b1;
                s_d.tag[up_set_i][victim]   = up_tag_i;
                s_d.ctr[up_set_i][victim]   = ctr_seed(up_taken_i);
                s_d.lru[up_set_i]           = ~victim;
            end
        end

        if (flush_i) begin
            s_d.valid = '0;
            s_d.lru   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
    import bdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int SET_W   = 6,
    parameter int TAG_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic [1:0]      mode_i,
    input  logic            lk_valid_i,
    input  logic [PC_W-1:0] lk_pc_i,
    input  logic            lk_disp_neg_i,
    output logic            lk_taken_o,
    output logic            lk_hit_o,
    input  logic            up_valid_i,
    input  logic [PC_W-1:0] up_pc_i,
    input  logic            up_taken_i
);

    localparam int WAYS    = 2;
    localparam int TAG_LSB = IDX_LSB + SET_W;
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    logic [SET_W-1:0]      lk_set, up_set;
    logic [TAG_W-1:0]      lk_tag, up_tag;
    logic [WAYS-1:0]       lk_vld, up_vld;
    logic [WAYS*TAG_W-1:0] lk_tags, up_tags;
    logic [WAYS*2-1:0]     lk_ctrs;
    logic                  lk_hit, lk_way, up_hit, up_way;
    ctr_t                  lk_ctr;

    assign lk_set = lk_pc_i[TAG_LSB-1:IDX_LSB];
    assign lk_tag = lk_pc_i[TAG_MSB:TAG_LSB];
    assign up_set = up_pc_i[TAG_LSB-1:IDX_LSB];
    assign up_tag = up_pc_i[TAG_MSB:TAG_LSB];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc_i[PC_W-1:TAG_MSB+1], lk_pc_i[IDX_LSB-1:0],
                              up_pc_i[PC_W-1:TAG_MSB+1], up_pc_i[IDX_LSB-1:0]};

    bdp_table #(.SET_W(SET_W), .TAG_W(TAG_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .lk_valid_i (lk_valid_i),
        .lk_set_i   (lk_set),
        .lk_hit_i   (lk_hit),
        .lk_way_i   (lk_way),
        .lk_valid_o (lk_vld),
        .lk_tags_o  (lk_tags),
        .lk_ctrs_o  (lk_ctrs),
        .up_valid_i (up_valid_i),
        .up_set_i   (up_set),
        .up_tag_i   (up_tag),
        .up_hit_i   (up_hit),
        .up_way_i   (up_way),
        .up_taken_i (up_taken_i),
        .up_valid_o (up_vld),
        .up_tags_o  (up_tags)
    );

    bdp_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
        .valid_i (lk_vld),
        .tags_i  (lk_tags),
        .tag_i   (lk_tag),
        .hit_o   (lk_hit),
        .way_o   (lk_way)
    );

    bdp_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_up_match (
        .valid_i (up_vld),
        .tags_i  (up_tags),
        .tag_i   (up_tag),
        .hit_o   (up_hit),
        .way_o   (up_way)
    );

    assign lk_ctr = lk_ctrs[lk_way*2 +: 2];

    bdp_strategy u_strategy (
        .mode_i     (mode_i),
        .disp_neg_i (lk_disp_neg_i),
        .hit_i      (lk_hit),
        .ctr_i      (lk_ctr),
        .taken_o    (lk_taken_o)
    );

    assign lk_hit_o = lk_hit;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush_i,
    input logic [1:0]      mode_i,
    input logic [PC_W-1:0] lk_pc_i,
    input logic            lk_disp_neg_i,
    input logic            lk_taken_o,
    input logic            lk_hit_o,
    input logic            up_valid_i,
    input logic [PC_W-1:0] up_pc_i
);

    assert_never_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> !lk_taken_o);

    assert_disp_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (lk_taken_o == lk_disp_neg_i));

    assert_miss_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && !lk_hit_o) |-> (lk_taken_o == lk_disp_neg_i));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !lk_hit_o);

    assert_update_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid_i) && !$past(flush_i) && (lk_pc_i == $past(up_pc_i)))
            |-> lk_hit_o);

endmodule

bind bdir_predictor bdp_checker #(.PC_W(PC_W)) u_bdp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .mode_i        (mode_i),
    .lk_pc_i       (lk_pc_i),
    .lk_disp_neg_i (lk_disp_neg_i),
    .lk_taken_o    (lk_taken_o),
    .lk_hit_o      (lk_hit_o),
    .up_valid_i    (up_valid_i),
    .up_pc_i       (up_pc_i)
);

// File: tb/tb_bdir_predictor.sv
`timescale 1ns/1ps
module tb_bdir_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [1:0]  mode_i = 2'b10;
    logic        lk_valid_i = 1'b0;
    logic [31:0] lk_pc_i = '0;
    logic        lk_disp_neg_i = 1'b0;
    logic        lk_taken_o, lk_hit_o;
    logic        up_valid_i = 1'b0;
    logic [31:0] up_pc_i = '0;
    logic        up_taken_i = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    bdir_predictor dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .mode_i(mode_i),
        .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i), .lk_disp_neg_i(lk_disp_neg_i),
        .lk_taken_o(lk_taken_o), .lk_hit_o(lk_hit_o),
        .up_valid_i(up_valid_i), .up_pc_i(up_pc_i), .up_taken_i(up_taken_i)
    );

    // behavioural model built from the requirements
    logic       m_valid [64][2];
    logic [7:0] m_tag   [64][2];
    logic [1:0] m_ctr   [64][2];
    logic       m_lru   [64];

    task automatic m_clear();
        for (int s = 0; s < 64; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) m_valid[s][w] = 1'b0;
        end
    endtask

    task automatic m_find(input logic [31:0] pc, output bit hit, output int way);
        int s = int'(pc[7:2]);
        hit = 0; way = 0;
        for (int w = 1; w >= 0; w--)
            if (m_valid[s][w] && m_tag[s][w] == pc[15:8]) begin hit = 1; way = w; end
    endtask

    task automatic m_predict(output bit hit, output bit taken);
        int way;
        m_find(lk_pc_i, hit, way);
        if (mode_i == 2'b00)      taken = 0;
        else if (mode_i == 2'b01) taken = lk_disp_neg_i;
        else taken = hit ? m_ctr[int'(lk_pc_i[7:2])][way][1] : lk_disp_neg_i;
    endtask

    task automatic m_apply();
        bit lh, uh; int lw, uw;
        int ls = int'(lk_pc_i[7:2]);
        int us = int'(up_pc_i[7:2]);
        logic old_lru;
        if (flush_i) begin m_clear(); return; end
        m_find(lk_pc_i, lh, lw);
        m_find(up_pc_i, uh, uw);
        old_lru = m_lru[us];
        if (lk_valid_i && lh) m_lru[ls] = (lw == 0);
        if (up_valid_i) begin
            if (uh) begin
                if (up_taken_i && m_ctr[us][uw] != 2'b11) m_ctr[us][uw] += 2'd1;
                if (!up_taken_i && m_ctr[us][uw] != 2'b00) m_ctr[us][uw] -= 2'd1;
            end else begin
                m_valid[us][old_lru] = 1'b1;
                m_tag[us][old_lru]   = up_pc_i[15:8];
                m_ctr[us][old_lru]   = up_taken_i ? 2'b10 : 2'b01;
                m_lru[us]            = ~old_lru;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_in(input logic fl, input logic [1:0] md, input logic lv,
                          input logic [31:0] lpc, input logic ln,
                          input logic uv, input logic [31:0] upc, input logic ut);
        flush_i = fl; mode_i = md; lk_valid_i = lv; lk_pc_i = lpc;
        lk_disp_neg_i = ln; up_valid_i = uv; up_pc_i = upc; up_taken_i = ut;
    endtask

    task automatic step();
        @(posedge clk);
        m_apply();
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] pc, input logic neg, input logic [1:0] md,
                        input bit eh, input bit et, input string req);
        set_in(0, md, 1, pc, neg, 0, 0, 0);
        #2;
        chk(lk_hit_o == eh, req, "hit", int'(lk_hit_o), int'(eh));
        chk(lk_taken_o == et, req, "taken", int'(lk_taken_o), int'(et));
        step();
    endtask

    task automatic upd(input logic [31:0] pc, input logic t);
        set_in(0, 2'b10, 0, 0, 0, 1, pc, t);
        step();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] e;
        bit ph, pt;
        bit pat [11] = '{1,1,1,1,0,0,0,0,0,1,1};
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset, every set; miss falls back to sign rule
        for (int s = 0; s < 64; s++) begin
            look({16'h0, 8'h3c, s[5:0], 2'b00}, s[0], 2'b10, 0, s[0], "R1");
        end

        // R7: seeds are weak states
        upd(32'h0000_1204, 1);
        look(32'h0000_1204, 0, 2'b10, 1, 1, "R7");
        upd(32'h0000_1204, 0);
        look(32'h0000_1204, 1, 2'b10, 1, 0, "R7");

        // R6: counter walk across both saturation points (start 01)
        e = 2'b01;
        for (int i = 0; i < 11; i++) begin
            upd(32'h0000_1204, pat[i]);
            if (pat[i] && e != 2'b11) e = e + 2'd1;
            if (!pat[i] && e != 2'b00) e = e - 2'd1;
            look(32'h0000_1204, !e[1], 2'b10, 1, e[1], "R6");
        end
        // e is now 10 (weakly taken)

        // R2: never-taken ignores a taken counter and sign
        look(32'h0000_1204, 1, 2'b00, 1, 0, "R2");
        look(32'h0000_1204, 0, 2'b00, 1, 0, "R2");
        // R3: displacement mode ignores counter
        look(32'h0000_1204, 0, 2'b01, 1, 0, "R3");
        look(32'h0000_1204, 1, 2'b01, 1, 1, "R3");
        // R4: code 11 behaves as history
        look(32'h0000_1204, 0, 2'b11, 1, 1, "R4");
        look(32'h0000_5604, 1, 2'b11, 0, 1, "R4");

        // R5: ignored bits alias, index/tag bits do not
        look(32'hABCD_1207, 0, 2'b10, 1, 1, "R5");
        look(32'h0000_1304, 0, 2'b10, 0, 0, "R5");
        look(32'h0000_1200, 0, 2'b10, 0, 0, "R5");
        look(32'h0000_1208, 0, 2'b10, 0, 0, "R5");

        // R8: replacement follows recency (set 5)
        upd(32'h0000_0114, 1);   // way0
        upd(32'h0000_0214, 0);   // way1
        look(32'h0000_0114, 0, 2'b10, 1, 1, "R8");  // way0 most recent
        upd(32'h0000_0314, 1);   // evicts 0x02
        look(32'h0000_0214, 1, 2'b10, 0, 1, "R8");
        look(32'h0000_0114, 0, 2'b10, 1, 1, "R8");
        look(32'h0000_0314, 0, 2'b10, 1, 1, "R8");
        upd(32'h0000_0214, 0);   // last lookup hit way1 -> evicts 0x01 in way0
        look(32'h0000_0114, 1, 2'b10, 0, 1, "R8");
        look(32'h0000_0214, 1, 2'b10, 1, 0, "R8");

        // R9: lookup hit and allocation in same set, same cycle (set 9)
        upd(32'h0000_0124, 1);   // way0
        upd(32'h0000_0224, 1);   // way1, recency -> way0
        set_in(0, 2'b10, 1, 32'h0000_0224, 0, 1, 32'h0000_0324, 0);
        #2;
        chk(lk_hit_o == 1, "R9", "hit same-cycle", int'(lk_hit_o), 1);
        step();                  // 0x03 replaces way0; allocation marks way1 next
        upd(32'h0000_0424, 1);   // must evict 0x02 (way1)
        look(32'h0000_0324, 1, 2'b10, 1, 0, "R9");
        look(32'h0000_0224, 0, 2'b10, 0, 0, "R9");
        look(32'h0000_0424, 0, 2'b10, 1, 1, "R9");
        look(32'h0000_0124, 0, 2'b10, 0, 0, "R9");

        // R11: same-cycle lookup sees old state
        set_in(0, 2'b10, 1, 32'h0000_0134, 0, 1, 32'h0000_0134, 1);
        #2;
        chk(lk_hit_o == 0, "R11", "hit before edge", int'(lk_hit_o), 0);
        step();
        look(32'h0000_0134, 0, 2'b10, 1, 1, "R11");

        // R10: flush overrides a same-cycle update
        set_in(1, 2'b10, 0, 0, 0, 1, 32'h0000_0144, 1);
        step();
        look(32'h0000_0144, 0, 2'b10, 0, 0, "R10");
        look(32'h0000_1204, 1, 2'b10, 0, 1, "R10");
        look(32'h0000_0134, 0, 2'b10, 0, 0, "R10");
        // recency reset: first allocation lands in way0, second in way1, both survive
        upd(32'h0000_0514, 1);
        upd(32'h0000_0614, 0);
        look(32'h0000_0514, 0, 2'b10, 1, 1, "R10");
        look(32'h0000_0614, 1, 2'b10, 1, 0, "R10");

        // random stream over four sets against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] lp, up;
            string rq;
            lp = {$urandom_range(0, 65535)} << 16 |
                 (32'($urandom_range(0, 3)) << 8) | (32'($urandom_range(0, 3)) << 2) |
                 32'($urandom_range(0, 3));
            up = (32'($urandom_range(0, 3)) << 8) | (32'($urandom_range(0, 3)) << 2);
            set_in(($urandom_range(0, 99) == 0), 2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), lp, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), up, 1'($urandom_range(0, 1)));
            #2;
            m_predict(ph, pt);
            rq = (mode_i == 2'b00) ? "R2" : (mode_i == 2'b01) ? "R3" : "R4";
            chk(lk_hit_o == ph, "R8", "random hit", int'(lk_hit_o), int'(ph));
            chk(lk_taken_o == pt, rq, "random taken", int'(lk_taken_o), int'(pt));
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule